// File: doc/BRIEF.md
# Periodic Auto-Reload Timer Comparator

This block pairs a free-running main counter with one comparator channel. While the global run bit is set, the counter advances by one each clock. When it reaches the value held in the comparator, the channel can raise an interrupt. In periodic mode the comparator then adds a separately stored period to itself, so the next match is scheduled without software help. The sum wraps modulo the counter width. Software reads the comparator to learn the next match point. The period cannot be read back; software has to remember it.

A plain word-wide register port gives access to several things: the run bit, the channel configuration, the interrupt status, the counter and the comparator. A compare write normally changes only the period, and the new period takes effect at the next addition. If software first sets the value-set bit, the next compare write loads the comparator and the period together, and the bit then clears itself. The interrupt output is either a one-cycle pulse per match (edge) or a copy of a status bit that software clears by writing 1 (level).

Register map (address, content): 0 run bit in bit 0; 1 channel configuration, with bit 0 interrupt enable, bit 1 periodic, bit 2 level mode and bit 3 value-set; 2 status, bit 0; 3 main counter; 4 comparator (reads the next match point, writes the period). Unused addresses read as zero.

Top module: `ptc_timer`

## Requirements
- R1: After reset the counter, comparator, run bit, configuration and status all read 0, and irq_o is low.
- R2: While the run bit (address 0, bit 0) is 1 and the counter is not being written, the counter reads one higher after each clock, wrapping from all-ones to 0.
- R3: A write to address 3 loads the counter on that clock, taking priority over the increment.
- R4: A match occurs when the incremented counter value equals the comparator. It sets status bit 0 only if configuration bit 0 (interrupt enable) is 1.
- R5: In periodic mode (configuration bit 1), each match adds the period to the comparator. This happens whether or not the interrupt is enabled. With a period of 0x123, the matches fall at 0x123, 0x246 and 0x369.
- R6: The comparator addition wraps modulo 2^32. A comparator of 0xFFFF0000 with a period of 0x20000 becomes 0x00010000 after its match.
- R7: A write to address 4 while configuration bit 3 is 0 changes only the period. The comparator read-back does not change, and the new period is first used at the next match.
- R8: A write to address 4 while configuration bit 3 (value-set) is 1 loads both the comparator and the period, and clears bit 3.
- R9: While the run bit is 0, the counter holds its value and no match or interrupt occurs.
- R10: In level mode (configuration bit 2 = 1), status bit 0 and irq_o stay high until a write of 1 to address 2 bit 0. Writing 0 there has no effect.
- R11: In edge mode (configuration bit 2 = 0), irq_o is high for exactly the one cycle after each enabled match, and no clearing is needed.
- R12: With periodic mode off, a match leaves the comparator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for reads and writes |
| reg_wdata_i | input | CNT_W | Write data |
| reg_rdata_o | output | CNT_W | Read data for reg_addr_i (combinational) |
| irq_o | output | 1 | Interrupt, a pulse or a level depending on the mode |

## Verification
Bad comparator or period state shows up at the ports on the first clock after the match that used it. The comparator read-back then differs from the arithmetic next point, and the following status edge lands on the wrong counter value. A stuck or skipped counter increment is visible in the counter read-back within one clock. A status bit that is set or cleared wrongly is visible on irq_o in level mode. In edge mode a wrong status or pulse shows as an irq_o pulse that is missing, stretched or late by one cycle. Sweeping many small periods makes every such slip surface within a few cycles of a scheduled match.

// File: rtl/ptc_pkg.sv
`timescale 1ns/1ps
package ptc_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_GLOBAL = 3'd0,
    A_CHAN   = 3'd1,
    A_STAT   = 3'd2,
    A_COUNT  = 3'd3,
    A_CMP    = 3'd4
  } reg_addr_e;

  localparam int unsigned CFG_W = 4;

  // bit 3 value-set, bit 2 level, bit 1 periodic, bit 0 irq enable
  typedef struct packed {
    logic vset;
    logic level;
    logic periodic;
    logic irq_en;
  } chan_cfg_t;
endpackage

// File: rtl/ptc_rst_sync.sv
`timescale 1ns/1ps
module ptc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/ptc_counter.sv
`timescale 1ns/1ps
module ptc_counter #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] inc_o,
  output logic         step_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;
  logic [W-1:0] inc;
  logic         step;

  always_comb begin
    inc  = cnt_q + W'(1);
    step = run_i & ~load_i;
    if (load_i)    cnt_d = load_val_i;
    else if (step) cnt_d = inc;
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign inc_o  = inc;
  assign step_o = step;
endmodule

// File: rtl/ptc_comparator.sv
`timescale 1ns/1ps
module ptc_comparator #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_n,
  input  logic         step_i,
  input  logic [W-1:0] cnt_inc_i,
  input  logic         periodic_i,
  input  logic         wr_i,
  input  logic         direct_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cmp_o,
  output logic [W-1:0] per_o,
  output logic         hit_o
);
  logic [W-1:0] cmp_q, cmp_d;
  logic [W-1:0] per_q, per_d;
  logic         hit;

  always_comb begin
    hit = step_i && (cnt_inc_i == cmp_q);
    if (wr_i && direct_i)      cmp_d = wdata_i;
    else if (hit && periodic_i) cmp_d = cmp_q + per_q;
    else                        cmp_d = cmp_q;
    per_d = wr_i ? wdata_i : per_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      per_q <= '0;
    end else begin
      cmp_q <= cmp_d;
      per_q <= per_d;
    end
  end

  assign cmp_o = cmp_q;
  assign per_o = per_q;
  assign hit_o = hit;
endmodule

// File: rtl/ptc_irq.sv
`timescale 1ns/1ps
module ptc_irq (
  input  logic clk_i,
  input  logic rst_n,
  input  logic hit_i,
  input  logic irq_en_i,
  input  logic level_i,
  input  logic clr_i,
  output logic sts_o,
  output logic irq_o
);
  logic sts_q, sts_d;
  logic pulse_q, pulse_d;
  logic fire;

  always_comb begin
    fire    = hit_i & irq_en_i;
    pulse_d = fire;
    if (fire)       sts_d = 1'b1;
    else if (clr_i) sts_d = 1'b0;
    else            sts_d = sts_q;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      sts_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sts_q   <= sts_d;
      pulse_q <= pulse_d;
    end
  end

  assign sts_o = sts_q;
  assign irq_o = level_i ? sts_q : pulse_q;
endmodule

// File: rtl/ptc_timer.sv
`timescale 1ns/1ps
module ptc_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      reg_we_i,
  input  logic [ptc_pkg::ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]          reg_wdata_i,
  output logic [CNT_W-1:0]          reg_rdata_o,
  output logic                      irq_o
);
  import ptc_pkg::*;

  logic              rst_n;
  reg_addr_e         addr;
  logic              we_glb, we_chan, we_stat, we_cnt, we_cmp, clr;
  logic              run_q, run_d;
  chan_cfg_t         cfg_q, cfg_d;
  logic [CNT_W-1:0]  cnt_q, cnt_inc, cmp_q, per_q;
  logic              step, hit, sts_q;

  ptc_rst_sync #(.STAGES(2)) u_rst (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n)
  );

  always_comb begin
    addr    = reg_addr_e'(reg_addr_i);
    we_glb  = reg_we_i && (addr == A_GLOBAL);
    we_chan = reg_we_i && (addr == A_CHAN);
    we_stat = reg_we_i && (addr == A_STAT);
    we_cnt  = reg_we_i && (addr == A_COUNT);
    we_cmp  = reg_we_i && (addr == A_CMP);
    clr     = we_stat && reg_wdata_i[0];
  end

  always_comb begin
    run_d = we_glb ? reg_wdata_i[0] : run_q;
    cfg_d = cfg_q;
    if (we_chan)                 cfg_d = chan_cfg_t'(reg_wdata_i[CFG_W-1:0]);
    else if (we_cmp && cfg_q.vset) cfg_d.vset = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cfg_q <= '0;
    end else begin
      run_q <= run_d;
      cfg_q <= cfg_d;
    end
  end

  ptc_counter #(.W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .run_i     (run_q),
    .load_i    (we_cnt),
    .load_val_i(reg_wdata_i),
    .cnt_o     (cnt_q),
    .inc_o     (cnt_inc),
    .step_o    (step)
  );

  ptc_comparator #(.W(CNT_W)) u_cmp (
    .clk_i     (clk_i),
    .rst_n     (rst_n),
    .step_i    (step),
    .cnt_inc_i (cnt_inc),
    .periodic_i(cfg_q.periodic),
    .wr_i      (we_cmp),
    .direct_i  (cfg_q.vset),
    .wdata_i   (reg_wdata_i),
    .cmp_o     (cmp_q),
    .per_o     (per_q),
    .hit_o     (hit)
  );

  ptc_irq u_irq (
    .clk_i   (clk_i),
    .rst_n   (rst_n),
    .hit_i   (hit),
    .irq_en_i(cfg_q.irq_en),
    .level_i (cfg_q.level),
    .clr_i   (clr),
    .sts_o   (sts_q),
    .irq_o   (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (addr)
      A_GLOBAL: reg_rdata_o[0]         = run_q;
      A_CHAN:   reg_rdata_o[CFG_W-1:0] = cfg_q;
      A_STAT:   reg_rdata_o[0]         = sts_q;
      A_COUNT:  reg_rdata_o            = cnt_q;
      A_CMP:    reg_rdata_o            = cmp_q;
      default:  reg_rdata_o            = '0;
    endcase
  end
endmodule

// File: rtl/ptc_timer_chk.sv
`timescale 1ns/1ps
module ptc_timer_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk_i,
  input logic         rst_n,
  input logic         run_q,
  input logic         we_cnt,
  input logic         we_cmp,
  input logic         clr,
  input logic [W-1:0] wdata,
  input logic [W-1:0] cnt_q,
  input logic [W-1:0] cmp_q,
  input logic [W-1:0] per_q,
  input logic         hit,
  input logic         irq_en,
  input logic         periodic,
  input logic         level,
  input logic         vset,
  input logic         sts_q,
  input logic         irq_o
);
  // R2
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    run_q && !we_cnt |=> cnt_q == $past(cnt_q) + W'(1));
  // R9
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !run_q && !we_cnt |=> $stable(cnt_q));
  // R9
  no_hit_halt_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !run_q |-> !hit);
  // R3
  cnt_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    we_cnt |=> cnt_q == $past(wdata));
  // R4
  sts_set_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit && irq_en |=> sts_q);
  // R4
  sts_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(sts_q) |-> $past(hit && irq_en));
  // R5
  cmp_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit && periodic && !we_cmp |=> cmp_q == $past(cmp_q) + $past(per_q));
  // R8
  vset_load_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    vset && we_cmp |=> (cmp_q == $past(wdata)) && !vset);
  // R7
  per_only_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !vset && we_cmp && !hit |=> $stable(cmp_q) && per_q == $past(wdata));
  // R10
  lvl_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    level && sts_q && !clr |=> sts_q);
  // R11
  edge_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !level && irq_o |-> $past(hit && irq_en));
  // R12
  oneshot_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    hit && !periodic && !we_cmp |=> $stable(cmp_q));
endmodule

bind ptc_timer ptc_timer_chk #(.W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_n   (rst_n),
  .run_q   (run_q),
  .we_cnt  (we_cnt),
  .we_cmp  (we_cmp),
  .clr     (clr),
  .wdata   (reg_wdata_i),
  .cnt_q   (cnt_q),
  .cmp_q   (cmp_q),
  .per_q   (per_q),
  .hit     (hit),
  .irq_en  (cfg_q.irq_en),
  .periodic(cfg_q.periodic),
  .level   (cfg_q.level),
  .vset    (cfg_q.vset),
  .sts_q   (sts_q),
  .irq_o   (irq_o)
);

// File: tb/ptc_timer_tb.sv
`timescale 1ns/1ps
module ptc_timer_tb;
  import ptc_pkg::*;

  logic        clk_i;
  logic        rst_ni;
  logic        reg_we_i;
  logic [2:0]  reg_addr_i;
  logic [31:0] reg_wdata_i;
  logic [31:0] reg_rdata_o;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  ptc_timer #(.CNT_W(32)) u_dut (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .irq_o      (irq_o)
  );

  initial begin
    clk_i = 1'b0;
    forever #4 clk_i = ~clk_i;
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chkreg(input string req, input logic [2:0] a, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    chk(req, $sformatf("reg%0d", a), reg_rdata_o, exp);
  endtask

  task automatic chkirq(input string req, input logic exp);
    chk(req, "irq_o", {31'b0, irq_o}, {31'b0, exp});
  endtask

  // stop, zero counter, clear status, program config with value-set, load compare
  task automatic setup(input logic [3:0] cfg, input logic [31:0] p);
    wr(A_GLOBAL, 0);
    wr(A_COUNT, 0);
    wr(A_STAT, 1);
    wr(A_CHAN, {28'b0, 1'b1, cfg[2:0]});
    wr(A_CMP, p);
    chkreg("R8", A_CHAN, {29'b0, cfg[2:0]});
    wr(A_GLOBAL, 1);
  endtask

  // level mode, interrupt enabled, three periodic matches
  task automatic run_periodic(input logic [31:0] p);
    setup(4'b0111, p);
    for (int k = 1; k <= 3; k++) begin
      step(k == 1 ? p - 1 : p - 2);
      chkreg("R5", A_COUNT, k * p - 1);
      chkreg("R4", A_STAT, 0);
      step(1);
      chkreg("R4", A_STAT, 1);
      chkirq("R4", 1'b1);
      chkreg("R5", A_CMP, (k + 1) * p);
      wr(A_STAT, 1);
      chkreg("R10", A_STAT, 0);
      chkirq("R10", 1'b0);
      chkreg("R2", A_COUNT, k * p + 1);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; reg_we_i = 1'b0; reg_addr_i = '0; reg_wdata_i = '0;
    step(3);
    rst_ni = 1'b1;
    step(3);

    // R1 reset state
    chkreg("R1", A_GLOBAL, 0);
    chkreg("R1", A_CHAN, 0);
    chkreg("R1", A_STAT, 0);
    chkreg("R1", A_COUNT, 0);
    chkreg("R1", A_CMP, 0);
    chkirq("R1", 1'b0);

    // R9 halted counter, no match
    wr(A_COUNT, 5);
    wr(A_CHAN, 4'b1101);
    wr(A_CMP, 6);
    step(10);
    chkreg("R9", A_COUNT, 5);
    chkreg("R9", A_STAT, 0);
    chkirq("R9", 1'b0);

    // R4 R5 sweep over small periods
    for (int p = 2; p <= 9; p++) run_periodic(p);
    // R5 example period
    run_periodic(32'h123);

    // R3 load while running
    wr(A_COUNT, 100);
    chkreg("R3", A_COUNT, 100);
    step(1);
    chkreg("R3", A_COUNT, 101);

    // R11 edge mode pulse
    setup(4'b0011, 4);
    step(3);
    chkirq("R11", 1'b0);
    step(1);
    chkirq("R11", 1'b1);
    chkreg("R11", A_STAT, 1);
    step(1);
    chkirq("R11", 1'b0);
    step(2);
    chkirq("R11", 1'b0);
    step(1);
    chkirq("R11", 1'b1);
    step(1);
    chkirq("R11", 1'b0);

    // R4 interrupt disabled: no status, comparator still advances (R5)
    setup(4'b0110, 3);
    step(3);
    chkreg("R4", A_STAT, 0);
    chkirq("R4", 1'b0);
    chkreg("R5", A_CMP, 6);

    // R10 write 0 ignored, write 1 clears
    setup(4'b0111, 3);
    step(3);
    chkreg("R10", A_STAT, 1);
    wr(A_STAT, 0);
    chkreg("R10", A_STAT, 1);
    chkirq("R10", 1'b1);
    wr(A_STAT, 1);
    chkreg("R10", A_STAT, 0);
    chkirq("R10", 1'b0);

    // R12 one-shot keeps comparator
    setup(4'b0101, 3);
    step(3);
    chkreg("R12", A_STAT, 1);
    chkreg("R12", A_CMP, 3);
    step(10);
    chkreg("R12", A_CMP, 3);

    // R6 R7 R8 wrap of comparator sum
    wr(A_GLOBAL, 0);
    wr(A_COUNT, 32'hFFFE_FFF0);
    wr(A_CHAN, 4'b1111);
    wr(A_CMP, 32'hFFFF_0000);
    chkreg("R8", A_CHAN, 4'b0111);
    chkreg("R8", A_CMP, 32'hFFFF_0000);
    wr(A_CMP, 32'h0002_0000);
    chkreg("R7", A_CMP, 32'hFFFF_0000);
    wr(A_STAT, 1);
    wr(A_GLOBAL, 1);
    step(15);
    chkreg("R7", A_COUNT, 32'hFFFE_FFFF);
    chkreg("R7", A_STAT, 0);
    step(1);
    chkreg("R6", A_STAT, 1);
    chkreg("R6", A_CMP, 32'h0001_0000);

    // R2 counter wrap
    wr(A_GLOBAL, 0);
    wr(A_COUNT, 32'hFFFF_FFFE);
    wr(A_GLOBAL, 1);
    step(1);
    chkreg("R2", A_COUNT, 32'hFFFF_FFFF);
    step(1);
    chkreg("R2", A_COUNT, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule